// File: doc/BRIEF.md
# Multi-Rate Stochastic Arithmetic Core

This block turns binary target values into unipolar stochastic bit streams and computes on them with single gates. Three stream generators each hold a 32-bit pseudo-random register and a tick divider of their own. Every generator advances at its own programmable rate, counted in cycles of a shared base clock, so the three streams switch at instants that are unrelated to each other. Stream A and stream B are multiplied by an AND gate. A 2:1 multiplexer forms the scaled sum (A+B)/2, and its select line is driven by a third stream whose target is one half.

Each result stream passes through a runt filter and then a window decoder. The filter drops high pulses that are shorter than a programmable number of base cycles. The decoder reads the stream back as a number: it counts the base-clock cycles in which the stream is high over a fixed window. The value of the result is that count divided by the window length, which is the fraction of time the stream was high. No per-bit alignment is needed.

To use the block, hold the targets, periods and filter threshold steady, release reset, and pulse `start`. When `done` rises, read the two counts.

Top module: `stoch_poly_core`

Finite-state machines:
- Runt filter states:
  - Hunt: waiting for a pulse.
  - Pass: the current pulse qualified and is forwarded.
  - Drop: the current pulse is a runt and is suppressed.
- Runt filter transitions:
  - Any state goes to Pass on a delayed rising edge whose first `runt_thr` cycles are all high.
  - Any state goes to Drop on a delayed rising edge that fails that test.
  - Pass and Drop go back to Hunt when the delayed stream falls.
- Decoder states: Idle, Count, Done.
- Decoder transitions:
  - Idle goes to Count on `start`.
  - Done goes to Count on `start`.
  - Count goes to Done on the last cycle of the window.

## Requirements
- R1: Each generator holds a 32-bit right-shifting Galois register. A step is `s = (s >> 1) ^ (s[0] ? 32'h80200003 : 0)`. Reset loads a per-generator nonzero seed (A `32'h1ACEB00C`, B `32'h5EED0042`, select `32'hC0FFEE11`). The register steps once per tick of its own generator and is never zero.
- R2: A generator with period p (1..63) ticks on the p-th, 2p-th, … rising clock edge after reset is released.
- R3: On each tick, the generator output becomes 1 when the low W bits of the register, taken before the step, are strictly less than the target; otherwise it becomes 0. The output holds between ticks and is 0 after reset.
- R4: The raw product stream is A AND B.
- R5: The raw sum stream is B when the select stream is 1 and A when it is 0. The select generator has target 2^(W-1).
- R6: Each filtered output is its raw stream delayed by RUNT_MAX cycles. A delayed pulse is forced to 0 unless its first `runt_thr` cycles are all high. `runt_thr` = 0 passes every pulse; values above RUNT_MAX act as RUNT_MAX.
- R7: When `start` is seen outside the Count state, both counts clear and exactly WIN cycles are counted. Each count then equals the number of those cycles in which its filtered stream was high. `done` is then 1, and the counts stay frozen until the next `start`.
- R8: Over a window, the decoded product lies within 0.04 of a·b and the decoded sum within 0.04 of (a+b)/2, where a = tgt_a/2^W and b = tgt_b/2^W.
- R9: While reset is asserted, `prod_bit`, `sum_bit`, both counts and `done` are 0.
- R10: A target of 0 gives a stream that is never high, so with `tgt_a` = 0 the product count is exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a measurement window |
| tgt_a | input | W | Target of operand stream A |
| tgt_b | input | W | Target of operand stream B |
| per_a | input | DW | Tick period of generator A in base cycles |
| per_b | input | DW | Tick period of generator B in base cycles |
| per_s | input | DW | Tick period of the select generator in base cycles |
| runt_thr | input | $clog2(RUNT_MAX+1) | Minimum accepted pulse length in base cycles |
| prod_bit | output | 1 | Filtered product stream |
| sum_bit | output | 1 | Filtered scaled-sum stream |
| prod_ones | output | $clog2(WIN+1) | High-cycle count of the product stream |
| sum_ones | output | $clog2(WIN+1) | High-cycle count of the sum stream |
| done | output | 1 | Window finished, counts valid |

## Verification
The embedded assertions check on every cycle the properties that hold cycle by cycle:
- each generator's register is nonzero;
- each generator's output holds between ticks and its phase counter stays below the period;
- a dropped pulse yields no output;
- a count never exceeds the cycles counted, is frozen after the window, and `done` rises only after exactly WIN counted cycles.

Only the bench's scenarios can show the rest. The exact tick schedules, the comparison results, the delay and runt decisions, and the window totals are matched against an independent model on every clock. The statistical accuracy of the product and the scaled sum under three sets of mismatched periods and thresholds, and the exact zero result, are checked at the end of each window.

// File: rtl/stoch_pkg.sv
package stoch_pkg;

    localparam logic [31:0] LFSR_MASK = 32'h8020_0003;

    typedef enum logic [1:0] {
        DEC_IDLE  = 2'd0,
        DEC_COUNT = 2'd1,
        DEC_DONE  = 2'd2
    } dec_state_t;

    typedef enum logic [1:0] {
        RF_HUNT = 2'd0,
        RF_PASS = 2'd1,
        RF_DROP = 2'd2
    } rf_state_t;

    function automatic logic [31:0] lfsr_step(input logic [31:0] s);
        return (s >> 1) ^ (s[0] ? LFSR_MASK : 32'h0);
    endfunction

endpackage

// File: rtl/stoch_sng.sv
module stoch_sng
    import stoch_pkg::*;
#(
    parameter int          W    = 10,
    parameter int          DW   = 6,
    parameter logic [31:0] SEED = 32'h1ACE_B00C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  target,
    input  logic [DW-1:0] period,
    output logic          stream_o
);

    logic [DW-1:0] phase_q;
    logic [31:0]   lfsr_q;
    logic          tick;

    // local tick: last phase of this generator's own period
    assign tick = (phase_q == period - DW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= '0;
            lfsr_q   <= SEED;
            stream_o <= 1'b0;
        end else if (tick) begin
            phase_q  <= '0;
            lfsr_q   <= lfsr_step(lfsr_q);
            stream_o <= (lfsr_q[W-1:0] < target);
        end else begin
            phase_q  <= phase_q + DW'(1);
        end
    end

    // R1: the pseudo-random register never locks up at zero
    assert_lfsr_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 32'h0);

    // R2: phase counter stays inside the programmed period
    assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (period != '0) |-> (phase_q < period));

    // R3: stream bit only changes on a tick
    assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(stream_o));

endmodule

// File: rtl/stoch_runt_filt.sv
module stoch_runt_filt
    import stoch_pkg::*;
#(
    parameter int D  = 8,
    parameter int TW = $clog2(D + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw_i,
    input  logic [TW-1:0] thr_i,
    output logic          filt_o
);

    logic [D:0]    sr_q;
    logic          del;
    logic          prev;
    logic          rise;
    logic          ok;
    logic [TW-1:0] thr_eff;
    logic [D-1:0]  need_m;
    rf_state_t     st_q;
    rf_state_t     st_d;

    // history: sr_q[j] is the raw stream j+1 cycles ago
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[D-1:0], raw_i};
    end

    assign del  = sr_q[D-1];
    assign prev = sr_q[D];
    assign rise = del & ~prev;

    always_comb begin
        thr_eff = (int'(thr_i) > D) ? TW'(D) : thr_i;
        for (int j = 0; j < D; j++) begin
            need_m[j] = (j >= D - int'(thr_eff));
        end
        // the first thr_eff cycles of the delayed pulse are already in sr_q
        ok = &(sr_q[D-1:0] | ~need_m);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RF_HUNT: if (rise) st_d = ok ? RF_PASS : RF_DROP;
            RF_PASS: if (rise) st_d = ok ? RF_PASS : RF_DROP;
                     else if (!del) st_d = RF_HUNT;
            RF_DROP: if (rise) st_d = ok ? RF_PASS : RF_DROP;
                     else if (!del) st_d = RF_HUNT;
            default: st_d = RF_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RF_HUNT;
        else        st_q <= st_d;
    end

    always_comb begin
        if (rise) filt_o = ok;
        else      filt_o = (st_q == RF_PASS) & del;
    end

    // R6: a pulse judged as a runt produces no output while it lasts
    assert_drop_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RF_DROP && !rise) |-> !filt_o);

    // R6: Hunt is only ever left through a delayed rising edge
    assert_hunt_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RF_HUNT && !rise) |=> (st_q == RF_HUNT));

endmodule

// File: rtl/stoch_window_dec.sv
module stoch_window_dec
    import stoch_pkg::*;
#(
    parameter int WIN = 40960,
    parameter int CW  = $clog2(WIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          bit_i,
    output logic [CW-1:0] ones_o,
    output logic          done_o
);

    dec_state_t    st_q;
    dec_state_t    st_d;
    logic [CW-1:0] cyc_q;
    logic          last;

    assign last = (cyc_q == CW'(WIN - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DEC_IDLE:  if (start) st_d = DEC_COUNT;
            DEC_COUNT: if (last)  st_d = DEC_DONE;
            DEC_DONE:  if (start) st_d = DEC_COUNT;
            default:   st_d = DEC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DEC_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            ones_o <= '0;
        end else if (st_q != DEC_COUNT && start) begin
            cyc_q  <= '0;
            ones_o <= '0;
        end else if (st_q == DEC_COUNT) begin
            cyc_q  <= cyc_q + CW'(1);
            ones_o <= ones_o + CW'(bit_i);
        end
    end

    assign done_o = (st_q == DEC_DONE);

    // R7: high count can never exceed the cycles observed
    assert_ones_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ones_o <= cyc_q);

    // R7: counts are frozen after the window closes
    assert_done_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DEC_DONE && !start) |=> $stable(ones_o));

    // R7: done rises only after exactly one full window
    assert_window_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (cyc_q == CW'(WIN)));

endmodule

// File: rtl/stoch_poly_core.sv
module stoch_poly_core #(
    parameter int          W        = 10,
    parameter int          DW       = 6,
    parameter int          RUNT_MAX = 8,
    parameter int          WIN      = 40960,
    parameter logic [31:0] SEED_A   = 32'h1ACE_B00C,
    parameter logic [31:0] SEED_B   = 32'h5EED_0042,
    parameter logic [31:0] SEED_S   = 32'hC0FF_EE11
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic [W-1:0]                    tgt_a,
    input  logic [W-1:0]                    tgt_b,
    input  logic [DW-1:0]                   per_a,
    input  logic [DW-1:0]                   per_b,
    input  logic [DW-1:0]                   per_s,
    input  logic [$clog2(RUNT_MAX+1)-1:0]   runt_thr,
    output logic                            prod_bit,
    output logic                            sum_bit,
    output logic [$clog2(WIN+1)-1:0]        prod_ones,
    output logic [$clog2(WIN+1)-1:0]        sum_ones,
    output logic                            done
);

    localparam int          NGEN = 3;
    localparam int          NOUT = 2;
    localparam int          TW   = $clog2(RUNT_MAX + 1);
    localparam int          CW   = $clog2(WIN + 1);
    localparam logic [31:0] SEEDS [NGEN] = '{SEED_A, SEED_B, SEED_S};

    logic [W-1:0]  tgt_v  [NGEN];
    logic [DW-1:0] per_v  [NGEN];
    logic          gen_b  [NGEN];
    logic          raw_v  [NOUT];
    logic          filt_v [NOUT];
    logic [CW-1:0] ones_v [NOUT];
    logic [NOUT-1:0] done_v;

    assign tgt_v[0] = tgt_a;
    assign tgt_v[1] = tgt_b;
    assign tgt_v[2] = W'(1) << (W - 1);
    assign per_v[0] = per_a;
    assign per_v[1] = per_b;
    assign per_v[2] = per_s;

    for (genvar g = 0; g < NGEN; g++) begin : g_sng
        stoch_sng #(.W(W), .DW(DW), .SEED(SEEDS[g])) sng_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .target   (tgt_v[g]),
            .period   (per_v[g]),
            .stream_o (gen_b[g])
        );
    end

    // product and select-driven scaled sum
    assign raw_v[0] = gen_b[0] & gen_b[1];
    assign raw_v[1] = gen_b[2] ? gen_b[1] : gen_b[0];

    for (genvar o = 0; o < NOUT; o++) begin : g_out
        stoch_runt_filt #(.D(RUNT_MAX), .TW(TW)) filt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_v[o]),
            .thr_i  (runt_thr),
            .filt_o (filt_v[o])
        );
        stoch_window_dec #(.WIN(WIN), .CW(CW)) dec_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (start),
            .bit_i  (filt_v[o]),
            .ones_o (ones_v[o]),
            .done_o (done_v[o])
        );
    end

    assign prod_bit  = filt_v[0];
    assign sum_bit   = filt_v[1];
    assign prod_ones = ones_v[0];
    assign sum_ones  = ones_v[1];
    assign done      = &done_v;

    // R4: both decoders share start, so they finish together
    assert_done_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_v[0] == done_v[1]);

endmodule

// File: tb/stoch_poly_core_tb.sv
`timescale 1ns/1ps
module stoch_poly_core_tb_top;

    localparam int W    = 10;
    localparam int DW   = 6;
    localparam int D    = 8;
    localparam int WIN  = 40960;
    localparam int TW   = $clog2(D + 1);
    localparam int CW   = $clog2(WIN + 1);
    localparam real TOL = 0.04;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  tgt_a = '0;
    logic [W-1:0]  tgt_b = '0;
    logic [DW-1:0] per_a = 6'd1;
    logic [DW-1:0] per_b = 6'd1;
    logic [DW-1:0] per_s = 6'd1;
    logic [TW-1:0] runt_thr = '0;
    logic          prod_bit;
    logic          sum_bit;
    logic [CW-1:0] prod_ones;
    logic [CW-1:0] sum_ones;
    logic          done;

    int n_cmp = 0;
    int n_bad = 0;
    bit running = 1'b0;

    always #5 clk = ~clk;

    stoch_poly_core dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .tgt_a(tgt_a), .tgt_b(tgt_b),
        .per_a(per_a), .per_b(per_b), .per_s(per_s),
        .runt_thr(runt_thr),
        .prod_bit(prod_bit), .sum_bit(sum_bit),
        .prod_ones(prod_ones), .sum_ones(sum_ones), .done(done)
    );

    // ---------------- reference model ----------------
    bit          rp_q[$];
    bit          rs_q[$];
    int          k;
    logic [31:0] m_lf  [3];
    int          m_cnt [3];
    bit          m_bit [3];
    int          m_per [3];
    int          m_tgt [3];
    int          m_thr;
    int          md_state;
    int          md_cyc;
    int          md_ones [2];

    function automatic bit hist(input int which, input int idx);
        if (idx < 0) return 1'b0;
        return (which != 0) ? rs_q[idx] : rp_q[idx];
    endfunction

    // delayed raw stream with pulses judged by their first m_thr cycles
    function automatic bit model_filt(input int which);
        int idx;
        int s;
        idx = k - D;
        if (idx < 0) return 1'b0;
        if (!hist(which, idx)) return 1'b0;
        s = idx;
        while (s > 0 && hist(which, s - 1)) s--;
        for (int i = 0; i < m_thr; i++)
            if (!hist(which, s + i)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_init();
        rp_q.delete();
        rs_q.delete();
        k = 0;
        m_lf[0] = 32'h1ACE_B00C;
        m_lf[1] = 32'h5EED_0042;
        m_lf[2] = 32'hC0FF_EE11;
        m_per[0] = int'(per_a);
        m_per[1] = int'(per_b);
        m_per[2] = int'(per_s);
        m_tgt[0] = int'(tgt_a);
        m_tgt[1] = int'(tgt_b);
        m_tgt[2] = 1 << (W - 1);
        for (int g = 0; g < 3; g++) begin
            m_cnt[g] = 0;
            m_bit[g] = 1'b0;
        end
        m_thr = (int'(runt_thr) > D) ? D : int'(runt_thr);
        md_state = 0;
        md_cyc = 0;
        md_ones[0] = 0;
        md_ones[1] = 0;
    endtask

    always @(posedge clk) begin
        if (rst_n && running) begin
            bit fp;
            bit fs;
            fp = model_filt(0);
            fs = model_filt(1);
            // R7 window decoder
            if (md_state != 1 && start) begin
                md_state = 1;
                md_cyc = 0;
                md_ones[0] = 0;
                md_ones[1] = 0;
            end else if (md_state == 1) begin
                md_ones[0] += int'(fp);
                md_ones[1] += int'(fs);
                md_cyc++;
                if (md_cyc == WIN) md_state = 2;
            end
            // R4 and R5 raw streams before this edge
            rp_q.push_back(m_bit[0] & m_bit[1]);
            rs_q.push_back(m_bit[2] ? m_bit[1] : m_bit[0]);
            // R1, R2, R3 generators
            for (int g = 0; g < 3; g++) begin
                if (m_cnt[g] == m_per[g] - 1) begin
                    m_bit[g] = (int'(m_lf[g] & ((32'h1 << W) - 1)) < m_tgt[g]);
                    if (m_lf[g][0]) m_lf[g] = (m_lf[g] >> 1) ^ 32'h8020_0003;
                    else            m_lf[g] = m_lf[g] >> 1;
                    m_cnt[g] = 0;
                end else begin
                    m_cnt[g]++;
                end
            end
            k++;
        end
    end

    task automatic check_int(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, k, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && running) begin
            check_int("R4", "prod_bit",  int'(prod_bit),  int'(model_filt(0)));
            check_int("R5", "sum_bit",   int'(sum_bit),   int'(model_filt(1)));
            check_int("R7", "prod_ones", int'(prod_ones), md_ones[0]);
            check_int("R7", "sum_ones",  int'(sum_ones),  md_ones[1]);
            check_int("R7", "done",      int'(done),      int'(md_state == 2));
        end
    end

    task automatic check_real(input string req, input string what, input real act, input real exp);
        n_cmp++;
        if (act - exp > TOL || exp - act > TOL) begin
            n_bad++;
            $display("FAIL %s %s: actual %f expected %f", req, what, act, exp);
        end
    endtask

    task automatic run_case(input int a, input int b, input int pa, input int pb,
                            input int ps, input int thr, input bit zero_a);
        real ea;
        real eb;
        int  guard;
        @(negedge clk);
        running = 1'b0;
        rst_n = 1'b0;
        tgt_a = W'(a);
        tgt_b = W'(b);
        per_a = DW'(pa);
        per_b = DW'(pb);
        per_s = DW'(ps);
        runt_thr = TW'(thr);
        model_init();
        repeat (3) @(negedge clk);
        // R9 reset state
        check_int("R9", "reset prod_bit",  int'(prod_bit),  0);
        check_int("R9", "reset sum_bit",   int'(sum_bit),   0);
        check_int("R9", "reset prod_ones", int'(prod_ones), 0);
        check_int("R9", "reset done",      int'(done),      0);
        rst_n = 1'b1;
        running = 1'b1;
        repeat (40) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!done && guard < WIN + 100) begin
            @(negedge clk);
            guard++;
        end
        repeat (5) @(negedge clk);
        ea = real'(a) / real'(1 << W);
        eb = real'(b) / real'(1 << W);
        // R8 accuracy of product and scaled sum
        check_real("R8", "product", real'(prod_ones) / real'(WIN), ea * eb);
        check_real("R8", "scaled sum", real'(sum_ones) / real'(WIN), (ea + eb) / 2.0);
        // R10 a zero operand gives an exactly zero product
        if (zero_a) check_int("R10", "zero product count", int'(prod_ones), 0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        // R6 threshold off, R8 product 0.6*0.5
        run_case(614, 512, 23, 31, 27, 0, 1'b0);
        // R6 threshold 2 cycles, R8 scaled sum of 0.25 and 0.5
        run_case(256, 512, 20, 37, 29, 2, 1'b0);
        // R10 zero target, R6 threshold 4, near-full operand B
        run_case(0, 1023, 25, 33, 21, 4, 1'b1);
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog: actual still running expected finished");
        summary();
        $finish;
    end

endmodule